// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block turns a free-running reference clock into two single-cycle enable pulses for the serial transmit and receive engines of a UART: a sample tick and a slower bit tick. Three settings, written through a small register port, decide the rates: a prescale select that either passes the reference clock straight through or divides it by eight, a 16-bit clock divisor, and an 8-bit per-bit divisor.

The sample tick fires once every `clock divisor` enabled cycles. The bit tick fires together with every `(bit divisor + 1)`-th sample tick. So the bit rate is the selected clock divided by `clock divisor × (bit divisor + 1)`. Writes that would give an illegal divisor are dropped without any signal, and the previous value stays in force. Divisor changes are taken up only when a counter reloads, so a period that has already started is never cut short. A change of the prescale select restarts every counter from zero.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, the clock divisor reads 0x28B, the bit divisor reads 0x0F and the prescale select reads 0. All counters start from zero, so the first sample tick comes on the 651st enabled cycle.
- R2: A write with `cfg_sel` = 1 loads the low 16 bits of `cfg_wdata` into the clock divisor. If those 16 bits are zero, the write is ignored and the old value is kept.
- R3: A write with `cfg_sel` = 2 loads the low 8 bits of `cfg_wdata` into the bit divisor. If those 8 bits are below 4, the write is ignored and the old value is kept.
- R4: A write with `cfg_sel` = 0 stores only `cfg_wdata` bit 0 as the prescale select. Select 1 enables the sample counter on one cycle in every eight. Select 0 enables it on every cycle. Writes with `cfg_sel` = 3 have no effect, and reads with `cfg_sel` = 3 return zero.
- R5: `sample_tick` is a one-cycle pulse on every `clock divisor`-th enabled cycle, counted from the last reload.
- R6: `bit_tick` is high only in a cycle where `sample_tick` is high. It marks every `(bit divisor + 1)`-th sample tick.
- R7: A new divisor value governs only the period that starts after the next tick of that counter, or after a restart.
- R8: A write that changes the prescale select clears the prescaler and both counters, reloads both limits, and suppresses both ticks in that cycle. A write of the same select value changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 prescale, 1 clock divisor, 2 bit divisor, 3 none |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the register picked by `cfg_sel` |
| sample_tick | output | 1 | Sample-rate enable pulse |
| bit_tick | output | 1 | Bit-rate enable pulse |

## Verification
The tick outputs are tried under four patterns, each compared cycle by cycle against a behavioural model:
- The reset defaults show the full-length first period.
- Small divisors with the prescaler off show the two counter ratios apart.
- The divide-by-eight path shows the enable gating.
- The corner of clock divisor 1 with bit divisor 255 shows the tick-every-enable case and the widest bit counter.

Divisor writes made in the middle of a period show whether a change is applied early or only at the reload. Writes that change the prescale select, and one that repeats the same select value, show whether a restart happens only on a real change. Read-back after the rejected divisor values (zero after masking, and below four) shows the masking and range checks.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  localparam int unsigned CLKDIV_W_DEF   = 16;
  localparam int unsigned BITDIV_W_DEF   = 8;
  localparam int unsigned PRE_LOG2_DEF   = 3;
  localparam int unsigned CLKDIV_MIN_DEF = 1;
  localparam int unsigned BITDIV_MIN_DEF = 4;
  localparam logic [15:0] CLKDIV_RST_DEF = 16'h028B;
  localparam logic [7:0]  BITDIV_RST_DEF = 8'h0F;

  typedef enum logic [1:0] {
    SEL_PRESCALE = 2'd0,
    SEL_CLKDIV   = 2'd1,
    SEL_BITDIV   = 2'd2,
    SEL_NONE     = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CLKDIV_W   = 16,
  parameter int unsigned BITDIV_W   = 8,
  parameter int unsigned CLKDIV_MIN = 1,
  parameter int unsigned BITDIV_MIN = 4,
  parameter logic [CLKDIV_W-1:0] CLKDIV_RST = CLKDIV_W'(16'h028B),
  parameter logic [BITDIV_W-1:0] BITDIV_RST = BITDIV_W'(8'h0F)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [1:0]          sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                prescale_o,
  output logic [CLKDIV_W-1:0] clkdiv_o,
  output logic [BITDIV_W-1:0] bitdiv_o,
  output logic                restart_o
);
  import baud_gen_pkg::*;

  // Range checks applied after truncation to the field width
  function automatic logic clkdiv_legal(input logic [DATA_W-1:0] v);
    return v[CLKDIV_W-1:0] >= CLKDIV_W'(CLKDIV_MIN);
  endfunction

  function automatic logic bitdiv_legal(input logic [DATA_W-1:0] v);
    return v[BITDIV_W-1:0] >= BITDIV_W'(BITDIV_MIN);
  endfunction

  logic prescale_q;
  logic [CLKDIV_W-1:0] clkdiv_q;
  logic [BITDIV_W-1:0] bitdiv_q;

  logic wr_prescale, wr_clkdiv, wr_bitdiv;
  logic clkdiv_accept, bitdiv_accept;

  assign wr_prescale   = we && (cfg_sel_e'(sel) == SEL_PRESCALE);
  assign wr_clkdiv     = we && (cfg_sel_e'(sel) == SEL_CLKDIV);
  assign wr_bitdiv     = we && (cfg_sel_e'(sel) == SEL_BITDIV);
  assign clkdiv_accept = wr_clkdiv && clkdiv_legal(wdata);
  assign bitdiv_accept = wr_bitdiv && bitdiv_legal(wdata);

  // Restart event: the prescale select really changes
  assign restart_o = wr_prescale && (wdata[0] != prescale_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prescale_q <= 1'b0;
      clkdiv_q   <= CLKDIV_RST;
      bitdiv_q   <= BITDIV_RST;
    end else begin
      if (wr_prescale)   prescale_q <= wdata[0];
      if (clkdiv_accept) clkdiv_q   <= wdata[CLKDIV_W-1:0];
      if (bitdiv_accept) bitdiv_q   <= wdata[BITDIV_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (cfg_sel_e'(sel))
      SEL_PRESCALE: rdata[0]            = prescale_q;
      SEL_CLKDIV:   rdata[CLKDIV_W-1:0] = clkdiv_q;
      SEL_BITDIV:   rdata[BITDIV_W-1:0] = bitdiv_q;
      default:      rdata               = '0;
    endcase
  end

  assign prescale_o = prescale_q;
  assign clkdiv_o   = clkdiv_q;
  assign bitdiv_o   = bitdiv_q;

  // R2: a rejected clock divisor write leaves the register untouched
  a_r2_clkdiv_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clkdiv && !clkdiv_accept) |=> $stable(clkdiv_q));

  // R2: the stored clock divisor never drops below its minimum
  a_r2_clkdiv_legal: assert property (@(posedge clk) disable iff (!rst_n)
    clkdiv_q >= CLKDIV_W'(CLKDIV_MIN));

  // R3: a rejected bit divisor write leaves the register untouched
  a_r3_bitdiv_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bitdiv && !bitdiv_accept) |=> $stable(bitdiv_q));

  // R3: the stored bit divisor never drops below its minimum
  a_r3_bitdiv_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bitdiv_q >= BITDIV_W'(BITDIV_MIN));

  // R4: without a prescale write, the select holds
  a_r4_select_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_prescale |=> $stable(prescale_q));

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned PRE_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic divide_en,
  input  logic restart,
  output logic en_o
);
  logic [PRE_LOG2-1:0] pcnt_q;
  logic wrap;

  assign wrap = &pcnt_q;
  assign en_o = !restart && (divide_en ? wrap : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)         pcnt_q <= '0;
    else if (restart)   pcnt_q <= '0;
    else if (divide_en) pcnt_q <= pcnt_q + 1'b1;
  end

  // R4: in divided mode two enables are never adjacent
  a_r4_prescale_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (divide_en && en_o) |=> !en_o);

  // R8: a restart leaves the prescaler at zero
  a_r8_prescale_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pcnt_q == '0));

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
  parameter int unsigned LIM_W = 16,
  parameter logic [LIM_W-1:0] RST_LIM = LIM_W'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [LIM_W-1:0] next_lim,
  output logic             tick_o,
  output logic             reload_o
);
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] lim_q;
  logic at_end;

  // Terminal count of the period in force
  function automatic logic is_last(input logic [LIM_W-1:0] c,
                                   input logic [LIM_W-1:0] l);
    return c == (l - 1'b1);
  endfunction

  assign at_end   = is_last(cnt_q, lim_q);
  assign tick_o   = en && !restart && at_end;
  assign reload_o = restart || tick_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= RST_LIM;
    end else if (reload_o) begin
      cnt_q <= '0;
      lim_q <= next_lim;
    end else if (en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: the count stays inside the period in force
  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim_q);

  // R7: the limit only moves at a reload
  a_r7_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_o |=> $stable(lim_q));

  // R8: a restart clears the count
  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CLKDIV_W   = baud_gen_pkg::CLKDIV_W_DEF,
  parameter int unsigned BITDIV_W   = baud_gen_pkg::BITDIV_W_DEF,
  parameter int unsigned PRE_LOG2   = baud_gen_pkg::PRE_LOG2_DEF,
  parameter int unsigned CLKDIV_MIN = baud_gen_pkg::CLKDIV_MIN_DEF,
  parameter int unsigned BITDIV_MIN = baud_gen_pkg::BITDIV_MIN_DEF,
  parameter logic [CLKDIV_W-1:0] CLKDIV_RST = CLKDIV_W'(baud_gen_pkg::CLKDIV_RST_DEF),
  parameter logic [BITDIV_W-1:0] BITDIV_RST = BITDIV_W'(baud_gen_pkg::BITDIV_RST_DEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              sample_tick,
  output logic              bit_tick
);
  localparam int unsigned BITLIM_W = BITDIV_W + 1;
  localparam logic [BITLIM_W-1:0] BITLIM_RST = {1'b0, BITDIV_RST} + 1'b1;

  // Bit period length in sample ticks
  function automatic logic [BITLIM_W-1:0] bit_limit(input logic [BITDIV_W-1:0] d);
    return {1'b0, d} + 1'b1;
  endfunction

  logic                prescale;
  logic [CLKDIV_W-1:0] clkdiv;
  logic [BITDIV_W-1:0] bitdiv;
  logic                restart;
  logic                pre_en;
  logic                sample_reload;
  logic                bit_reload;

  baud_cfg_regs #(
    .DATA_W(DATA_W), .CLKDIV_W(CLKDIV_W), .BITDIV_W(BITDIV_W),
    .CLKDIV_MIN(CLKDIV_MIN), .BITDIV_MIN(BITDIV_MIN),
    .CLKDIV_RST(CLKDIV_RST), .BITDIV_RST(BITDIV_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .prescale_o(prescale), .clkdiv_o(clkdiv),
    .bitdiv_o(bitdiv), .restart_o(restart)
  );

  baud_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .divide_en(prescale), .restart(restart),
    .en_o(pre_en)
  );

  baud_div_counter #(.LIM_W(CLKDIV_W), .RST_LIM(CLKDIV_RST)) u_sample_cnt (
    .clk(clk), .rst_n(rst_n), .en(pre_en), .restart(restart),
    .next_lim(clkdiv), .tick_o(sample_tick), .reload_o(sample_reload)
  );

  baud_div_counter #(.LIM_W(BITLIM_W), .RST_LIM(BITLIM_RST)) u_bit_cnt (
    .clk(clk), .rst_n(rst_n), .en(sample_tick), .restart(restart),
    .next_lim(bit_limit(bitdiv)), .tick_o(bit_tick), .reload_o(bit_reload)
  );

  // R6: a bit tick always coincides with a sample tick
  a_r6_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  // R8: no tick leaves the block in a restart cycle
  a_r8_quiet_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !(sample_tick || bit_tick));

  // R7: the bit counter reloads only on a sample reload
  a_r7_bit_reload_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bit_reload |-> sample_reload);

endmodule

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sample_tick, bit_tick;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_pre, m_scnt, m_slim, m_bcnt, m_blim;
  int m_sel_div8, m_clkdiv, m_bitdiv;

  always #2 clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  task automatic check_bit(input string tag, input string what,
                           input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // One cycle: drive, compare at mid-cycle, advance the model, wait next negedge
  task automatic step(input logic we, input logic [1:0] sel,
                      input logic [31:0] d, input string tag);
    bit restart, pre, es, eb;
    int exp_rd;
    cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    #1;
    restart = we && sel == 2'd0 && (int'(d[0]) != m_sel_div8);
    pre = !restart && (m_sel_div8 != 0 ? (m_pre == 7) : 1'b1);
    es  = pre && (m_scnt == m_slim - 1);
    eb  = es && (m_bcnt == m_blim - 1);
    check_bit(tag, "sample_tick", sample_tick, es);
    check_bit(tag, "bit_tick", bit_tick, eb);
    if (!we) begin
      case (sel)
        2'd0: exp_rd = m_sel_div8;
        2'd1: exp_rd = m_clkdiv;
        2'd2: exp_rd = m_bitdiv;
        default: exp_rd = 0;
      endcase
      checks++;
      if (cfg_rdata !== 32'(exp_rd)) begin
        fails++;
        $display("FAIL %s rdata sel %0d actual 0x%0h expected 0x%0h",
                 tag, sel, cfg_rdata, exp_rd);
      end
    end
    if (restart) begin
      m_pre = 0; m_scnt = 0; m_bcnt = 0;
      m_slim = m_clkdiv; m_blim = m_bitdiv + 1;
    end else begin
      if (m_sel_div8 != 0) m_pre = (m_pre + 1) % 8;
      if (es) begin m_scnt = 0; m_slim = m_clkdiv; end
      else if (pre) m_scnt++;
      if (eb) begin m_bcnt = 0; m_blim = m_bitdiv + 1; end
      else if (es) m_bcnt++;
    end
    if (we) begin
      case (sel)
        2'd0: m_sel_div8 = int'(d[0]);
        2'd1: if ((d & 32'hFFFF) >= 1) m_clkdiv = int'(d & 32'hFFFF);
        2'd2: if ((d & 32'hFF) >= 4) m_bitdiv = int'(d & 32'hFF);
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'(i % 4), 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_pre = 0; m_scnt = 0; m_bcnt = 0;
    m_clkdiv = 651; m_bitdiv = 15; m_sel_div8 = 0;
    m_slim = 651; m_blim = 16;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values, then the full first period
    step(1'b0, 2'd0, 32'h0, "R1");
    step(1'b0, 2'd1, 32'h0, "R1");
    step(1'b0, 2'd2, 32'h0, "R1");
    step(1'b0, 2'd3, 32'h0, "R1");
    run(700, "R1");
    // R2: masked-to-zero and zero writes dropped, legal write kept
    step(1'b1, 2'd1, 32'h0001_0000, "R2");
    run(4, "R2");
    step(1'b1, 2'd1, 32'h0, "R2");
    run(4, "R2");
    step(1'b1, 2'd1, 32'h0003_0007, "R2");
    run(4, "R2");
    // R3: below-four writes dropped, masked legal write kept
    step(1'b1, 2'd2, 32'h3, "R3");
    run(4, "R3");
    step(1'b1, 2'd2, 32'h103, "R3");
    run(4, "R3");
    step(1'b1, 2'd2, 32'h205, "R3");
    run(4, "R3");
    // R7: old period finishes before the new divisors apply
    run(700, "R7");
    step(1'b1, 2'd1, 32'h3, "R5");
    step(1'b1, 2'd2, 32'h4, "R6");
    run(200, "R6");
    // R4 / R8: switch on divide-by-eight, counters restart
    step(1'b1, 2'd0, 32'h1, "R8");
    run(300, "R4");
    step(1'b1, 2'd1, 32'h2, "R7");
    run(100, "R7");
    // R8: change back (upper bits ignored), then same-value write
    step(1'b1, 2'd0, 32'hFFFF_FFFE, "R8");
    run(50, "R8");
    step(1'b1, 2'd0, 32'h0, "R8");
    run(20, "R8");
    // R5 / R6 corner: divisor 1, bit divisor 255
    step(1'b1, 2'd1, 32'h1, "R5");
    step(1'b1, 2'd2, 32'hFF, "R6");
    run(600, "R6");
    // R4: unused select writes nothing
    step(1'b1, 2'd3, 32'hFFFF_FFFF, "R4");
    run(8, "R4");
    finish_run();
  end

endmodule